// File: doc/BRIEF.md
# Spiking Winner-Take-All Neuron Array

This block is a clocked, discrete-time model of one square grid of integrate-and-fire neurons wired for hard winner-take-all selection. There are 64 slots. Slots 0 to 61 are excitatory neurons laid out row by row on an 8-wide grid. Slot 62 is the local inhibitory unit, which every excitatory spike drives. Slot 63 is the cross-population inhibitory unit, which an external pulse drives. Spike events come in on two address ports. Each event adds a programmable weight to the membrane of the neuron it names. A neuron whose membrane reaches the threshold fires, and its index leaves the block on a valid/ready event stream.

With the winner-take-all connections enabled, the first neuron to fire triggers the local inhibitory unit on the next cycle. That unit wipes the accumulated potential of every other excitatory neuron that is not refractory. The winner reloads a self-excitation value, and its grid neighbours receive a lateral boost, so the winner and its surroundings tend to win the next round. With the connections disabled, every neuron integrates and fires on its own. Several such arrays can compete with one another: the local inhibitory events of the other arrays are fed into the cross-inhibition input.

Top module: `wta_pop`

## Requirements
- R1: After reset, no output event is offered (`out_valid` low) until input events arrive.
- R2: A neuron of index 0..61 fires on the input event that brings its membrane to at least `cfg_thresh`. With weight 10 and threshold 60, that is the sixth event. Its index is offered on `out_addr` in the cycle after that event.
- R3: With the winner-take-all connections disabled, a neuron that fires restarts from zero, so its next spike needs the full count of events again.
- R4: After firing, a neuron stays refractory for `cfg_refr` cycles. Input events that reach it in that time are lost.
- R5: Every `cfg_leak_period` cycles (0 means never), the membrane drops by `cfg_leak_amt` and saturates at zero without wrapping. Within one cycle, input is applied first, then leak, then the threshold comparison.
- R6: The two input ports add independently, so two events to one neuron in one cycle add twice the weight. Events addressed to slots 62 and 63 have no effect.
- R7: With `wta_en` low, no slot-62 event is produced, and the membranes of the other neurons are untouched when a neuron fires.
- R8: With `wta_en` high, each cycle that contains an excitatory spike is followed one cycle later by a slot-62 firing. That firing clears every non-refractory excitatory membrane. Input added in that same cycle still counts. The slot-62 event is offered two cycles after the excitatory input.
- R9: With `wta_en` high, a firing neuron reloads its membrane to `cfg_self_w` instead of zero. The value survives the following inhibition if `cfg_refr` is at least 1.
- R10: With `wta_en` high, a spike adds `cfg_lat_w` on the next cycle to each in-grid north, south, west and east neighbour below slot 62. Grid rows do not wrap, so slot 7 is not a neighbour of slot 8.
- R11: A pulse on `xinh_in` while `xinh_en` is high fires slot 63 in that cycle. The firing clears all non-refractory excitatory membranes and is offered as an event on the next cycle. While `xinh_en` is low, the pulse is ignored.
- R12: Pending events are offered one per cycle. Slot 62 goes first, then slot 63, then the lowest-indexed excitatory neuron. While `out_ready` is low, `out_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev0_valid | input | 1 | Input event on port 0 |
| ev0_addr | input | 6 | Target slot of port-0 event |
| ev1_valid | input | 1 | Input event on port 1 |
| ev1_addr | input | 6 | Target slot of port-1 event |
| wta_en | input | 1 | Enables local inhibition, self and lateral excitation |
| xinh_en | input | 1 | Enables cross-population inhibition |
| xinh_in | input | 1 | Cross-population inhibitory pulse |
| cfg_weight | input | 12 | Weight added per input event |
| cfg_thresh | input | 12 | Firing threshold |
| cfg_self_w | input | 12 | Membrane reload of a winner when `wta_en` is high |
| cfg_lat_w | input | 12 | Lateral weight to grid neighbours |
| cfg_leak_amt | input | 12 | Leak subtracted per leak tick |
| cfg_leak_period | input | 8 | Cycles between leak ticks, 0 disables |
| cfg_refr | input | 4 | Refractory cycles after a spike |
| out_ready | input | 1 | Consumer accepts the offered event |
| out_valid | output | 1 | An event is offered |
| out_addr | output | 6 | Slot index of the offered event |

## Verification
The bench targets the cycle of a spike. A design that compares before adding, or that forgets to reset the membrane, fires one event early or late. Leak is driven far below zero: a subtractor that wraps instead of saturating would fire on the next single event. The row boundary between slots 7 and 8 catches neighbour logic that treats the grid as linear. Staggered inhibition, self-excitation and refractory cases show whether an inhibited membrane loses its charge, whether a refractory winner keeps its reload, and whether events are lost in the refractory window. A stalled output with three simultaneous sources checks that nothing is dropped and that the fixed priority order holds.

// File: rtl/wta_pkg.sv
// Shared helpers for the winner-take-all array.
// Assumes slots are numbered row by row; the last two slots are inhibitory.
package wta_pkg;

    localparam int NUM_DIRS = 4;

    // Returns the slot index of a grid neighbour of slot k in direction dir
    // (0 north, 1 south, 2 west, 3 east), or -1 if it is off the grid or
    // not an excitatory slot.
    function automatic int nbr_index(int k, int dir, int rows, int cols, int nexc);
        int r;
        int c;
        int n;
        r = k / cols;
        c = k % cols;
        n = -1;
        case (dir)
            0: if (r > 0)        n = k - cols;
            1: if (r < rows - 1) n = k + cols;
            2: if (c > 0)        n = k - 1;
            3: if (c < cols - 1) n = k + 1;
            default: n = -1;
        endcase
        if (n >= nexc) n = -1;
        return n;
    endfunction

endpackage

// File: rtl/wta_leak_timer.sv
// Leak tick generator: pulses leak_tick once every cfg_period cycles.
// Assumes cfg_period == 0 disables leak; a period change takes effect at
// the next wrap or immediately if the count already exceeds it.
module wta_leak_timer #(
    parameter int unsigned LEAK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEAK_W-1:0] cfg_period,
    output logic              leak_tick
);

    logic [LEAK_W-1:0] cnt_q;

    // Tick when the count reaches the last cycle of the period.
    always_comb begin
        leak_tick = (cfg_period != '0) && (cnt_q >= cfg_period - LEAK_W'(1));
    end

    // Free-running period counter, held at zero while leak is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_period == '0 || leak_tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + LEAK_W'(1);
        end
    end

    assert_leak_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (leak_tick && cfg_period > LEAK_W'(1)) |=>
            (!leak_tick || cfg_period != $past(cfg_period)));

endmodule

// File: rtl/wta_neuron.sv
// One excitatory integrate-and-fire neuron.
// Per cycle: optional clear by inhibition, add input and lateral weight
// (saturating), subtract leak (saturating at zero), compare to threshold.
// Assumes the caller gates lat_cnt with the winner-take-all enable.
module wta_neuron #(
    parameter int unsigned MEM_W  = 12,
    parameter int unsigned REFR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        hit_cnt,
    input  logic [2:0]        lat_cnt,
    input  logic              inhibit,
    input  logic              leak_tick,
    input  logic              wta_en,
    input  logic [MEM_W-1:0]  cfg_weight,
    input  logic [MEM_W-1:0]  cfg_lat_w,
    input  logic [MEM_W-1:0]  cfg_self_w,
    input  logic [MEM_W-1:0]  cfg_thresh,
    input  logic [MEM_W-1:0]  cfg_leak_amt,
    input  logic [REFR_W-1:0] cfg_refr,
    output logic              fire
);

    localparam int unsigned SUM_W = MEM_W + 3;
    localparam logic [SUM_W-1:0] MEM_MAX = SUM_W'({MEM_W{1'b1}});

    logic [MEM_W-1:0]  mem_q;
    logic [REFR_W-1:0] refr_q;
    logic              refractory;
    logic [SUM_W-1:0]  sum;
    logic [MEM_W-1:0]  sat;
    logic [MEM_W-1:0]  leaked;

    // Membrane update path: clear, integrate, saturate, leak, compare.
    always_comb begin
        refractory = (refr_q != '0);
        sum = (inhibit ? '0 : SUM_W'(mem_q))
            + SUM_W'(hit_cnt) * SUM_W'(cfg_weight)
            + SUM_W'(lat_cnt) * SUM_W'(cfg_lat_w);
        sat = (sum > MEM_MAX) ? {MEM_W{1'b1}} : sum[MEM_W-1:0];
        if (leak_tick) begin
            leaked = (sat > cfg_leak_amt) ? sat - cfg_leak_amt : '0;
        end else begin
            leaked = sat;
        end
        fire = !refractory && (leaked >= cfg_thresh);
    end

    // Membrane and refractory state; a refractory neuron holds its membrane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q  <= '0;
            refr_q <= '0;
        end else if (refractory) begin
            refr_q <= refr_q - REFR_W'(1);
        end else if (fire) begin
            mem_q  <= wta_en ? cfg_self_w : '0;
            refr_q <= cfg_refr;
        end else begin
            mem_q  <= leaked;
        end
    end

    assert_refr_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cfg_refr != '0) |=> !fire);

endmodule

// File: rtl/wta_out_arb.sv
// Output event arbiter: one pending bit per slot, one event offered per
// cycle. Priority: local inhibitory slot, cross inhibitory slot, then the
// lowest excitatory index. Assumes a slot that fires again while still
// pending merges into the existing pending bit.
module wta_out_arb #(
    parameter int unsigned NSLOT = 64,
    parameter int unsigned AW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] set_vec,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [AW-1:0]    out_addr
);

    localparam int unsigned NEXC = NSLOT - 2;
    localparam int unsigned INH1 = NSLOT - 2;
    localparam int unsigned INH2 = NSLOT - 1;

    logic [NSLOT-1:0] pending_q;
    logic [NSLOT-1:0] clr_vec;

    // Fixed-priority selection among pending slots.
    always_comb begin
        out_addr = '0;
        for (int i = NEXC - 1; i >= 0; i--) begin
            if (pending_q[i]) out_addr = AW'(i);
        end
        if (pending_q[INH2]) out_addr = AW'(INH2);
        if (pending_q[INH1]) out_addr = AW'(INH1);
        out_valid = |pending_q;
    end

    // Clear mask for the slot accepted this cycle.
    always_comb begin
        clr_vec = '0;
        if (out_valid && out_ready) clr_vec[out_addr] = 1'b1;
    end

    // Pending set/clear; a new firing wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
        end else begin
            pending_q <= (pending_q & ~clr_vec) | set_vec;
        end
    end

    assert_valid_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);

endmodule

// File: rtl/wta_pop.sv
// Top of one winner-take-all neuron array.
// Holds the excitatory neurons, lateral wiring, the two inhibitory units
// and the output arbiter. Assumes input events are always accepted and
// that configuration inputs are held steady while events flow.
module wta_pop #(
    parameter int unsigned ROWS   = 8,
    parameter int unsigned COLS   = 8,
    parameter int unsigned MEM_W  = 12,
    parameter int unsigned REFR_W = 4,
    parameter int unsigned LEAK_W = 8,
    localparam int unsigned NSLOT = ROWS * COLS,
    localparam int unsigned AW    = $clog2(NSLOT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev0_valid,
    input  logic [AW-1:0]     ev0_addr,
    input  logic              ev1_valid,
    input  logic [AW-1:0]     ev1_addr,
    input  logic              wta_en,
    input  logic              xinh_en,
    input  logic              xinh_in,
    input  logic [MEM_W-1:0]  cfg_weight,
    input  logic [MEM_W-1:0]  cfg_thresh,
    input  logic [MEM_W-1:0]  cfg_self_w,
    input  logic [MEM_W-1:0]  cfg_lat_w,
    input  logic [MEM_W-1:0]  cfg_leak_amt,
    input  logic [LEAK_W-1:0] cfg_leak_period,
    input  logic [REFR_W-1:0] cfg_refr,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [AW-1:0]     out_addr
);

    localparam int unsigned NEXC = NSLOT - 2;

    logic [NEXC-1:0]  exc_fire;
    logic [NEXC-1:0]  spk_q;
    logic             inh1_q;
    logic             inh2_fire;
    logic             inhibit;
    logic             leak_tick;
    logic [NSLOT-1:0] set_vec;

    // Cross-population unit fires in the cycle of an enabled pulse.
    always_comb begin
        inh2_fire = xinh_en && xinh_in;
        inhibit   = inh1_q || inh2_fire;
        set_vec   = {inh2_fire, inh1_q, exc_fire};
    end

    // Spike history for lateral excitation and the local inhibitory unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spk_q  <= '0;
            inh1_q <= 1'b0;
        end else begin
            spk_q  <= exc_fire;
            inh1_q <= wta_en && (|exc_fire);
        end
    end

    wta_leak_timer #(.LEAK_W(LEAK_W)) u_leak (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_period (cfg_leak_period),
        .leak_tick  (leak_tick)
    );

    for (genvar k = 0; k < NEXC; k++) begin : g_nrn
        logic [wta_pkg::NUM_DIRS-1:0] nb;
        logic [1:0] hit_cnt;
        logic [2:0] lat_cnt;

        for (genvar d = 0; d < wta_pkg::NUM_DIRS; d++) begin : g_dir
            localparam int NI = wta_pkg::nbr_index(k, d, ROWS, COLS, NEXC);
            if (NI >= 0) begin : g_on
                assign nb[d] = spk_q[NI];
            end else begin : g_off
                assign nb[d] = 1'b0;
            end
        end

        // Count input hits on both ports and gated neighbour spikes.
        always_comb begin
            hit_cnt = {1'b0, ev0_valid && (ev0_addr == AW'(k))}
                    + {1'b0, ev1_valid && (ev1_addr == AW'(k))};
            lat_cnt = wta_en ? ({2'b0, nb[0]} + {2'b0, nb[1]}
                              + {2'b0, nb[2]} + {2'b0, nb[3]}) : 3'd0;
        end

        wta_neuron #(.MEM_W(MEM_W), .REFR_W(REFR_W)) u_nrn (
            .clk          (clk),
            .rst_n        (rst_n),
            .hit_cnt      (hit_cnt),
            .lat_cnt      (lat_cnt),
            .inhibit      (inhibit),
            .leak_tick    (leak_tick),
            .wta_en       (wta_en),
            .cfg_weight   (cfg_weight),
            .cfg_lat_w    (cfg_lat_w),
            .cfg_self_w   (cfg_self_w),
            .cfg_thresh   (cfg_thresh),
            .cfg_leak_amt (cfg_leak_amt),
            .cfg_refr     (cfg_refr),
            .fire         (exc_fire[k])
        );
    end

    wta_out_arb #(.NSLOT(NSLOT), .AW(AW)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_addr  (out_addr)
    );

    assert_inh1_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wta_en && (|exc_fire)) |=> ##1 out_valid);

    assert_xinh_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (xinh_en && xinh_in) |=> out_valid);

endmodule

// File: tb/wta_pop_test.sv
// Directed bench for wta_pop: one task per scenario, each checking itself.
module wta_pop_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev0_valid = 1'b0, ev1_valid = 1'b0;
    logic [5:0]  ev0_addr = '0, ev1_addr = '0;
    logic        wta_en = 1'b0, xinh_en = 1'b0, xinh_in = 1'b0;
    logic [11:0] cfg_weight, cfg_thresh, cfg_self_w, cfg_lat_w, cfg_leak_amt;
    logic [7:0]  cfg_leak_period;
    logic [3:0]  cfg_refr;
    logic        out_ready = 1'b1;
    logic        out_valid;
    logic [5:0]  out_addr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int ev_n = 0;
    int ev_addr [0:127];
    int ev_cyc  [0:127];

    always #5 clk = ~clk;

    wta_pop uut (
        .clk(clk), .rst_n(rst_n),
        .ev0_valid(ev0_valid), .ev0_addr(ev0_addr),
        .ev1_valid(ev1_valid), .ev1_addr(ev1_addr),
        .wta_en(wta_en), .xinh_en(xinh_en), .xinh_in(xinh_in),
        .cfg_weight(cfg_weight), .cfg_thresh(cfg_thresh),
        .cfg_self_w(cfg_self_w), .cfg_lat_w(cfg_lat_w),
        .cfg_leak_amt(cfg_leak_amt), .cfg_leak_period(cfg_leak_period),
        .cfg_refr(cfg_refr), .out_ready(out_ready),
        .out_valid(out_valid), .out_addr(out_addr)
    );

    // Event monitor: samples just before each rising edge.
    always begin
        @(negedge clk);
        #4;
        cyc++;
        if (rst_n && out_valid && out_ready && ev_n < 128) begin
            ev_addr[ev_n] = int'(out_addr);
            ev_cyc[ev_n]  = cyc;
            ev_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_count(input string req, input int exp);
        chk(ev_n == exp, req, ev_n, exp);
    endtask

    task automatic chk_ev(input string req, input int idx, input int exp);
        chk(ev_n > idx && ev_addr[idx] == exp, req, (ev_n > idx) ? ev_addr[idx] : -1, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int a, input int n);
        repeat (n) begin
            ev0_valid = 1'b1;
            ev0_addr  = 6'(a);
            @(negedge clk);
        end
        ev0_valid = 1'b0;
    endtask

    task automatic do_reset(input bit wta);
        @(negedge clk);
        rst_n = 1'b0;
        ev0_valid = 1'b0; ev1_valid = 1'b0; xinh_in = 1'b0; xinh_en = 1'b0;
        wta_en = wta; out_ready = 1'b1;
        cfg_weight = 12'd10; cfg_thresh = 12'd60; cfg_self_w = 12'd0;
        cfg_lat_w = 12'd0; cfg_leak_amt = 12'd0; cfg_leak_period = 8'd0;
        cfg_refr = 4'd0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        ev_n = 0;
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
        idle(20);
        chk_count("R1 idle events", 0);
    endtask

    task automatic t_threshold;
        do_reset(1'b0);
        send(5, 5); idle(3);
        chk_count("R2 below threshold", 0);
        send(5, 1); idle(3);
        chk_count("R2 at threshold", 1);
        chk_ev("R2 address", 0, 5);
        send(5, 5); idle(3);
        chk_count("R3 restart from zero", 1);
        send(5, 1); idle(3);
        chk_count("R3 second spike", 2);
    endtask

    task automatic t_dual;
        do_reset(1'b0);
        repeat (2) begin
            ev0_valid = 1'b1; ev0_addr = 6'd30; ev1_valid = 1'b1; ev1_addr = 6'd30;
            @(negedge clk);
        end
        ev0_valid = 1'b0; ev1_valid = 1'b0; idle(3);
        chk_count("R6 two ports partial", 0);
        ev0_valid = 1'b1; ev1_valid = 1'b1; @(negedge clk);
        ev0_valid = 1'b0; ev1_valid = 1'b0; idle(3);
        chk_count("R6 two ports fire", 1);
        chk_ev("R6 two ports addr", 0, 30);
        repeat (10) begin
            ev0_valid = 1'b1; ev0_addr = 6'd62; ev1_valid = 1'b1; ev1_addr = 6'd63;
            @(negedge clk);
        end
        ev0_valid = 1'b0; ev1_valid = 1'b0; idle(4);
        chk_count("R6 inhibitory slots ignored", 1);
    endtask

    task automatic t_refr;
        do_reset(1'b0);
        cfg_refr = 4'd3;
        send(9, 15); idle(3);
        chk_count("R4 refractory spikes", 2);
        chk((ev_n == 2) && (ev_cyc[1] - ev_cyc[0] == 9), "R4 refractory gap",
            (ev_n == 2) ? ev_cyc[1] - ev_cyc[0] : -1, 9);
    endtask

    task automatic t_leak;
        do_reset(1'b0);
        cfg_leak_amt = 12'd10; cfg_leak_period = 8'd16;
        send(12, 5);
        idle(120);
        cfg_leak_period = 8'd0;
        idle(1);
        send(12, 1); idle(3);
        chk_count("R5 leak saturates at zero", 0);
        send(12, 4); idle(3);
        chk_count("R5 drained membrane", 0);
        send(12, 1); idle(3);
        chk_count("R5 refill fires", 1);
    endtask

    task automatic t_wta_off;
        do_reset(1'b0);
        send(40, 5);
        send(10, 6); idle(4);
        chk_count("R7 no inhibitory event", 1);
        send(40, 1); idle(3);
        chk_count("R7 other membrane kept", 2);
        chk_ev("R7 other neuron fires", 1, 40);
    endtask

    task automatic t_wta_on;
        do_reset(1'b1);
        send(40, 5);
        send(10, 6); idle(4);
        chk_count("R8 winner and inhibition", 2);
        chk_ev("R8 winner first", 0, 10);
        chk_ev("R8 inhibitory slot", 1, 62);
        send(40, 1); idle(4);
        chk_count("R8 loser cleared", 2);
        send(40, 5); idle(4);
        chk_count("R8 loser restarts", 4);
        chk_ev("R8 loser fires", 2, 40);
    endtask

    task automatic t_self;
        do_reset(1'b1);
        cfg_self_w = 12'd30; cfg_refr = 4'd1;
        send(20, 6); idle(4);
        chk_count("R9 first win", 2);
        send(20, 3); idle(4);
        chk_count("R9 self excitation", 4);
        chk_ev("R9 winner again", 2, 20);
    endtask

    task automatic t_lat;
        do_reset(1'b1);
        cfg_lat_w = 12'd20;
        send(9, 6); idle(4);
        chk_count("R10 seed spike", 2);
        send(10, 4); idle(4);
        chk_count("R10 neighbour boost", 4);
        chk_ev("R10 neighbour addr", 2, 10);
        send(7, 6); idle(4);
        chk_count("R10 edge seed", 6);
        send(8, 4); idle(4);
        chk_count("R10 no row wrap", 6);
        send(8, 2); idle(4);
        chk_count("R10 full count past edge", 8);
        chk_ev("R10 edge addr", 6, 8);
    endtask

    task automatic t_xinh;
        do_reset(1'b0);
        xinh_en = 1'b1;
        send(33, 5);
        xinh_in = 1'b1; @(negedge clk); xinh_in = 1'b0; idle(3);
        chk_count("R11 cross event", 1);
        chk_ev("R11 cross slot", 0, 63);
        send(33, 1); idle(3);
        chk_count("R11 membrane cleared", 1);
        send(33, 5); idle(3);
        chk_count("R11 refill", 2);
        xinh_en = 1'b0;
        send(34, 5);
        xinh_in = 1'b1; @(negedge clk); xinh_in = 1'b0; idle(3);
        chk_count("R11 disabled pulse ignored", 2);
        send(34, 1); idle(3);
        chk_count("R11 membrane kept", 3);
        chk_ev("R11 kept neuron fires", 2, 34);
    endtask

    task automatic t_arb;
        do_reset(1'b0);
        xinh_en = 1'b1;
        out_ready = 1'b0;
        repeat (6) begin
            ev0_valid = 1'b1; ev0_addr = 6'd20; ev1_valid = 1'b1; ev1_addr = 6'd3;
            @(negedge clk);
        end
        ev0_valid = 1'b0; ev1_valid = 1'b0;
        xinh_in = 1'b1; @(negedge clk); xinh_in = 1'b0;
        idle(3);
        chk(out_valid == 1'b1, "R12 valid held while stalled", int'(out_valid), 1);
        chk(int'(out_addr) == 63, "R12 inhibitory first", int'(out_addr), 63);
        out_ready = 1'b1;
        idle(6);
        chk_count("R12 all drained", 3);
        chk_ev("R12 order 0", 0, 63);
        chk_ev("R12 order 1", 1, 3);
        chk_ev("R12 order 2", 2, 20);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Scenario sequence.
    initial begin
        t_reset();
        t_threshold();
        t_dual();
        t_refr();
        t_leak();
        t_wta_off();
        t_wta_on();
        t_self();
        t_lat();
        t_xinh();
        t_arb();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule